// File: doc/BRIEF.md
# Fractional SPI Clock Profile Generator

This block produces the serial clock of an SPI master together with two single-cycle strobes: one that tells the shifter when to drive the next output bit and one that tells it when to sample the incoming bit. The rate comes from a phase accumulator that counts modulo 2048. Each reference cycle it adds a per-profile increment. The serial clock follows the accumulator's top bit, so one SCK period takes 2048 / increment reference cycles.

Eight timing profiles are presented to the block as parallel configuration inputs. A 3-bit index picks the live one. Each profile has an increment, a loop-clear flag, a launch-edge select, a latch-edge select and a retimed-input option that delays the sample strobe by one reference cycle for fast links. The transaction engine drives `run`. While `run` is low, SCK sits at the idle level given by `cpol` and no strobes are issued.

Top module: `spi_clk_profile_gen`

## Requirements
- R1: While `rst` is high, `sck`, `launch` and `latch` are all 0 at the next clock edge.
- R2: A clock edge with `run` low makes `sck` equal to `cpol` and `launch` equal to 0. `latch` is 0 unless a delayed sample strobe from R7 is still due.
- R3: With `run` high, the accumulator adds the selected increment modulo 2048 at every edge. `sck` equals `cpol` XOR accumulator bit 10 after the add. An increment that divides 2048 therefore gives an SCK period of 2048 / increment cycles.
- R4: An increment above 1024 behaves as 1024, so SCK toggles at every running edge. An increment of 0 never toggles SCK.
- R5: `launch` pulses for one cycle, in the same cycle that `sck` shows its new level. It fires on a rising SCK edge when the profile's launch-rise bit is 1 and on a falling SCK edge when that bit is 0.
- R6: `latch` follows the same rule as R5, using the profile's latch-rise bit, when the retimed-input bit is 0.
- R7: When the retimed-input bit is 1, `latch` is issued one reference cycle after the edge selected by R6.
- R8: At an edge with `run` low, the accumulator is cleared if the profile's loop-clear bit is 1 and holds its value otherwise. With loop-clear set and increment 256, `sck` first leaves idle at the fourth running edge.
- R9: Profile fields are taken from slot `prof_sel`. Field k of profile p is bit p of each single-bit vector, and bits [14p+13:14p] of `prof_freq`.
- R10: Rising and falling in R5 and R6 refer to the `sck` pin itself. With `cpol` = 1, the idle level is high and a rising edge corresponds to the accumulator bit 10 falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High while the transaction engine wants clocks |
| cpol | input | 1 | Idle level of SCK |
| prof_sel | input | 3 | Index of the active profile |
| prof_freq | input | 112 | Eight 14-bit increments, profile p at [14p+13:14p] |
| prof_loop_clr | input | 8 | Per-profile accumulator clear while stopped |
| prof_launch_rise | input | 8 | Per-profile launch on rising SCK edge (else falling) |
| prof_latch_rise | input | 8 | Per-profile latch on rising SCK edge (else falling) |
| prof_retime | input | 8 | Per-profile one-cycle delay of the latch strobe |
| sck | output | 1 | Serial clock |
| launch | output | 1 | Drive-next-bit strobe |
| latch | output | 1 | Sample-input strobe |

## Verification
A wrong accumulator value shows on `sck` as early or late edges. With small increments it can take up to half an SCK period to appear, and it then persists, because the error carries forward in the accumulator. A wrong edge-select or polarity decode shows within one SCK half-period as a strobe that coincides with the opposite `sck` level. A failed clear or hold while stopped shows at the first edge after `run` returns. The bench models the accumulator and compares all three outputs every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/spi_prof_pkg.sv
package spi_prof_pkg;
  localparam int FREQ_W = 14;
  localparam int MODULUS = 2048;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic              loop_clr;
    logic              launch_rise;
    logic              latch_rise;
    logic              retime;
  } prof_cfg_t;
endpackage

// File: rtl/prof_select.sv
module prof_select
  import spi_prof_pkg::*;
#(
  parameter int NPROF = 8,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [NPROF*FREQ_W-1:0] freq_flat,
  input  logic [NPROF-1:0]        loop_clr,
  input  logic [NPROF-1:0]        launch_rise,
  input  logic [NPROF-1:0]        latch_rise,
  input  logic [NPROF-1:0]        retime,
  output prof_cfg_t               cfg
);
  prof_cfg_t slots [NPROF];

  for (genvar p = 0; p < NPROF; p++) begin : g_slot
    assign slots[p].freq        = freq_flat[p*FREQ_W +: FREQ_W];
    assign slots[p].loop_clr    = loop_clr[p];
    assign slots[p].launch_rise = launch_rise[p];
    assign slots[p].latch_rise  = latch_rise[p];
    assign slots[p].retime      = retime[p];
  end

  assign cfg = slots[sel];
endmodule

// File: rtl/phase_acc.sv
module phase_acc
  import spi_prof_pkg::*;
#(
  parameter int MOD = MODULUS,
  localparam int ACC_W = $clog2(MOD),
  localparam int HALF = MOD / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clr_idle,
  input  logic [FREQ_W-1:0] freq,
  output logic              phase_next,
  output logic              phase_up,
  output logic              phase_down
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    step = (freq > FREQ_W'(HALF)) ? ACC_W'(HALF) : freq[ACC_W-1:0];
    sum  = {1'b0, acc_q} + {1'b0, step};
    if (run)           acc_d = sum[ACC_W-1:0];
    else if (clr_idle) acc_d = '0;
    else               acc_d = acc_q;
  end

  assign phase_next = sum[ACC_W-1];
  assign phase_up   = run && !acc_q[ACC_W-1] &&  sum[ACC_W-1];
  assign phase_down = run &&  acc_q[ACC_W-1] && !sum[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  // R4: a clamped step crosses a half boundary on every running cycle
  p_clamp_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (run && freq >= FREQ_W'(HALF)) |-> (phase_up || phase_down));
  // R8: cleared while stopped with loop-clear
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && clr_idle) |=> (acc_q == '0));
  // R8: held while stopped without loop-clear
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr_idle) |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/edge_strobes.sv
module edge_strobes (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cpol,
  input  logic launch_rise,
  input  logic latch_rise,
  input  logic retime,
  input  logic phase_next,
  input  logic phase_up,
  input  logic phase_down,
  output logic sck_o,
  output logic launch_o,
  output logic latch_o
);
  logic pin_rise, pin_fall;
  logic launch_now, latch_now;
  logic latch_pend_q;

  always_comb begin
    pin_rise   = cpol ? phase_down : phase_up;
    pin_fall   = cpol ? phase_up   : phase_down;
    launch_now = launch_rise ? pin_rise : pin_fall;
    latch_now  = latch_rise  ? pin_rise : pin_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_o        <= 1'b0;
      launch_o     <= 1'b0;
      latch_o      <= 1'b0;
      latch_pend_q <= 1'b0;
    end else begin
      sck_o        <= run ? (phase_next ^ cpol) : cpol;
      launch_o     <= launch_now;
      latch_o      <= retime ? latch_pend_q : latch_now;
      latch_pend_q <= latch_now;
    end
  end

  // R2: stopped means idle level and no launch
  p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sck_o == $past(cpol) && !launch_o));
  // R5: launch strobe sits on the level the selected edge leads to
  p_launch_level_r5: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> (sck_o == $past(launch_rise)));
endmodule

// File: rtl/spi_clk_profile_gen.sv
module spi_clk_profile_gen
  import spi_prof_pkg::*;
#(
  parameter int NPROF = 8,
  parameter int MOD = MODULUS,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    cpol,
  input  logic [SEL_W-1:0]        prof_sel,
  input  logic [NPROF*FREQ_W-1:0] prof_freq,
  input  logic [NPROF-1:0]        prof_loop_clr,
  input  logic [NPROF-1:0]        prof_launch_rise,
  input  logic [NPROF-1:0]        prof_latch_rise,
  input  logic [NPROF-1:0]        prof_retime,
  output logic                    sck,
  output logic                    launch,
  output logic                    latch
);
  prof_cfg_t cfg;
  logic ph_next, ph_up, ph_down;

  prof_select #(.NPROF(NPROF)) u_sel (
    .sel(prof_sel), .freq_flat(prof_freq), .loop_clr(prof_loop_clr),
    .launch_rise(prof_launch_rise), .latch_rise(prof_latch_rise),
    .retime(prof_retime), .cfg(cfg)
  );

  phase_acc #(.MOD(MOD)) u_acc (
    .clk(clk), .rst(rst), .run(run), .clr_idle(cfg.loop_clr),
    .freq(cfg.freq), .phase_next(ph_next), .phase_up(ph_up),
    .phase_down(ph_down)
  );

  edge_strobes u_str (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol),
    .launch_rise(cfg.launch_rise), .latch_rise(cfg.latch_rise),
    .retime(cfg.retime), .phase_next(ph_next), .phase_up(ph_up),
    .phase_down(ph_down), .sck_o(sck), .launch_o(launch), .latch_o(latch)
  );

  // R1: reset clears the outputs
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!sck && !launch && !latch));
endmodule

// File: tb/tb_spi_clk_profile_gen.sv
`timescale 1ns/1ps
module tb_spi_clk_profile_gen;
  localparam int NP = 8;
  localparam int FW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic cpol = 1'b0;
  logic [2:0] sel = '0;
  logic [FW-1:0] pf [NP];
  logic [NP-1:0] plc = '0, plr = '0, ptr = '0, prt = '0;
  logic [NP*FW-1:0] pflat;
  logic sck, launch, latch;

  always #2.5 clk = ~clk;

  always_comb
    for (int p = 0; p < NP; p++) pflat[p*FW +: FW] = pf[p];

  spi_clk_profile_gen dut (
    .clk(clk), .rst(rst), .run(run), .cpol(cpol), .prof_sel(sel),
    .prof_freq(pflat), .prof_loop_clr(plc), .prof_launch_rise(plr),
    .prof_latch_rise(ptr), .prof_retime(prt),
    .sck(sck), .launch(launch), .latch(latch)
  );

  int n_chk = 0, n_bad = 0;
  int m_acc = 0;
  bit m_pend = 0, e_sck = 0, e_launch = 0, e_latch = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model of one clock edge, from the requirements
  task automatic model_edge();
    int f, stp, sum;
    bit up, dn, pr, pfl, ln, lt;
    if (rst) begin
      m_acc = 0; m_pend = 0; e_sck = 0; e_launch = 0; e_latch = 0;
      return;
    end
    f = int'(pf[sel]);
    stp = (f > 1024) ? 1024 : f;
    if (run) begin
      sum = m_acc + stp;
      up = (m_acc < 1024) && (sum >= 1024);
      dn = (m_acc >= 1024) && (sum >= 2048);
      m_acc = sum % 2048;
      e_sck = (m_acc >= 1024) ^ cpol;
      pr = cpol ? dn : up;
      pfl = cpol ? up : dn;
      ln = plr[sel] ? pr : pfl;
      lt = ptr[sel] ? pr : pfl;
    end else begin
      if (plc[sel]) m_acc = 0;
      e_sck = cpol; ln = 0; lt = 0;
    end
    e_launch = ln;
    e_latch = prt[sel] ? m_pend : lt;
    m_pend = lt;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(run ? "R3 sck" : "R2 sck", sck, e_sck);
    chk("R5 launch", launch, e_launch);
    chk(prt[sel] ? "R7 latch" : "R6 latch", latch, e_latch);
  endtask

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, prev;
    void'($urandom(32'h1234_5eed));
    for (int p = 0; p < NP; p++) pf[p] = '0;
    @(negedge clk);
    repeat (3) step();
    chk("R1 sck", sck, 0); chk("R1 launch", launch, 0); chk("R1 latch", latch, 0);
    rst = 1'b0;

    // R2 / R10: idle high with cpol set
    cpol = 1'b1; pf[0] = 14'd256; plc[0] = 1'b1;
    repeat (3) step();
    chk("R2 R10 idle high", sck, 1);

    // R8: loop-clear start, first edge at 4th running cycle
    cpol = 1'b0; step();
    run = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R8 first edge", sck, (i == 4) ? 1 : 0);
    end
    // R3: 8 rising edges in 64 cycles for increment 256
    cnt = 0; prev = sck;
    for (int i = 0; i < 64; i++) begin
      step();
      if (sck && !prev) cnt++;
      prev = sck;
    end
    chk("R3 period", cnt, 8);

    // R4: oversized increment toggles each cycle
    pf[0] = 14'd5000; cnt = 0; prev = sck;
    for (int i = 0; i < 16; i++) begin
      step();
      if (sck != prev) cnt++;
      prev = sck;
    end
    chk("R4 clamp", cnt, 16);

    // R9: profile 3 fast, profile 5 zero
    run = 1'b0; pf[3] = 14'd1024; pf[5] = 14'd0; plc[3] = 1; plc[5] = 1;
    sel = 3'd3; step(); step(); run = 1'b1;
    cnt = 0; prev = sck;
    for (int i = 0; i < 10; i++) begin step(); if (sck != prev) cnt++; prev = sck; end
    chk("R9 slot3", cnt, 10);
    sel = 3'd5; step(); cnt = 0; prev = sck;
    for (int i = 0; i < 10; i++) begin step(); if (sck != prev) cnt++; prev = sck; end
    chk("R9 slot5", cnt, 0);

    // R8: hold without loop-clear, then resume
    run = 1'b0; sel = 3'd1; pf[1] = 14'd300; plc[1] = 1'b0; step();
    run = 1'b1; repeat (5) step();
    run = 1'b0; repeat (3) step();
    run = 1'b1; repeat (12) step();

    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      run = 1'b0;
      for (int p = 0; p < NP; p++) begin
        pf[p] = ($urandom % 8 == 0) ? FW'($urandom) : FW'($urandom % 600);
      end
      plc = NP'($urandom); plr = NP'($urandom);
      ptr = NP'($urandom); prt = NP'($urandom);
      sel = 3'($urandom);
      cpol = 1'($urandom);
      repeat (2 + $urandom % 4) step();
      run = 1'b1;
      repeat (20 + $urandom % 180) step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule